// File: doc/BRIEF.md
# Phase-Aware Register Access Guard

This block sits on the register bus of a crypto accelerator. It owns the registers that software writes: the mode register, the input data words, and the interrupt mask. It also returns the output data words that the cipher datapath drives in. Three plain phase inputs tell it what the engine is doing: data processing running, DMA transfer mode selected, and round-key expansion running. From these it decides, for every bus access, whether that access is allowed in the current phase.

A forbidden access does not take effect. A forbidden read returns zero, and a forbidden write leaves its target untouched. The access also raises a sticky detection flag and stores a 3-bit code that names the kind of violation. Only the most recent code is kept. The flag and the code sit in a status word. Only a software reset command clears them. The flag, ANDed with a mask bit, drives an interrupt line.

All registers are 32-bit words at word addresses. Control is at 0, mode at 1, mask-set at 2, mask-clear at 3, mask readback at 4 and status at 5. The input data words start at 8 and the output data words start at 16, with four words in each group by default.

Top module: `regaccess_guard`

## Requirements
- R1: Any illegal access sets the detection flag (status word bit 0, address 5) at the next clock edge. The flag then stays set until a software reset.
- R2: The violation code sits in status bits [10:8]. The codes are: 0 = input word written during processing in DMA mode, 1 = output word read during processing, 2 = mode written during processing, 3 = output word read during key expansion, 4 = mode written during key expansion, 5 = write-only register read.
- R3: A later violation replaces the stored code with its own code.
- R4: Only a write to the control register (address 0) with bit 0 set clears the flag and the code. The same write also clears the mode register, the input words and the mask. Reading the status word, writing it, writing control with bit 0 clear, or using mask-clear leaves the flag and the code unchanged.
- R5: Writing an input word (addresses 8..11) is illegal only when processing is running and DMA mode is active at the same time.
- R6: Reading an output word (addresses 16..19) is illegal during processing (code 1) or during key expansion (code 3). If both phases are active, code 3 wins.
- R7: Writing the mode register is illegal during processing (code 2) or during key expansion (code 4). If both phases are active, code 4 wins.
- R8: Reading a write-only register (control 0, mask-set 2, mask-clear 3, input words 8..11) is illegal with code 5 in every phase.
- R9: An illegal read returns zero on the read data bus. Legal reads return their contents: mode at 1, mask in bit 0 at 4, status at 5, output words at 16..19. Unmapped addresses read as zero.
- R10: An illegal write is blocked, so the mode register or input word it targeted keeps its previous value.
- R11: The interrupt output equals the flag ANDed with the mask bit. Writing bit 0 = 1 to address 2 sets the mask, and writing bit 0 = 1 to address 3 clears it.
- R12: When the read and write strobes are both asserted, the access is checked both as a read and as a write. A write violation's code takes precedence. A software reset in that same cycle wins, and the flag and code read back as zero.
- R13: Writes to read-only or unmapped addresses have no effect and are not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (zero when not reading or when illegal) |
| proc_busy | input | 1 | Data processing running |
| dma_mode | input | 1 | DMA transfer mode selected |
| keygen_busy | input | 1 | Round-key expansion running |
| dout_words | input | NUM_WORDS*DATA_W | Output data words from the datapath |
| mode_q | output | DATA_W | Current mode register |
| din_words | output | NUM_WORDS*DATA_W | Current input data words |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every access kind over all eight combinations of the three phase inputs and over every data word. It checks the read data, the stored code, the interrupt and the targeted register against a model it computes itself.

The sweep targets these failures:
- A guard that used OR instead of AND for the DMA rule would flag input writes in phases where they are legal.
- A swapped priority would report code 1 or 2 where 3 or 4 is due.
- A missing block would let a forbidden write change the mode or input words.

Directed sequences target the clearing rules. A status read or write must not clear the flag, and a later violation must overwrite the earlier code. With both strobes active, a design with the wrong precedence would show code 5 instead of code 0, or would keep the flag after a software reset.

// File: rtl/rag_pkg.sv
package rag_pkg;

  localparam int OFF_CTRL   = 0;
  localparam int OFF_MODE   = 1;
  localparam int OFF_IEN    = 2;
  localparam int OFF_IDIS   = 3;
  localparam int OFF_IMASK  = 4;
  localparam int OFF_STATUS = 5;

  typedef enum logic [2:0] {
    VC_DIN_DMA   = 3'd0,
    VC_DOUT_PROC = 3'd1,
    VC_MODE_PROC = 3'd2,
    VC_DOUT_KEY  = 3'd3,
    VC_MODE_KEY  = 3'd4,
    VC_WO_READ   = 3'd5
  } viol_e;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_MODE, RG_IEN, RG_IDIS,
    RG_IMASK, RG_STATUS, RG_DIN, RG_DOUT
  } region_e;

  typedef struct packed {
    logic  hit;
    viol_e code;
  } verdict_t;

  localparam verdict_t NO_VIOL = '{hit: 1'b0, code: VC_DIN_DMA};

  // Read rules: output words are phase-guarded, write-only regions never readable
  function automatic verdict_t read_verdict(region_e r, logic proc, logic key);
    verdict_t v;
    v = NO_VIOL;
    case (r)
      RG_DOUT: begin
        if (key)       v = '{hit: 1'b1, code: VC_DOUT_KEY};
        else if (proc) v = '{hit: 1'b1, code: VC_DOUT_PROC};
      end
      RG_CTRL, RG_IEN, RG_IDIS, RG_DIN:
        v = '{hit: 1'b1, code: VC_WO_READ};
      default: v = NO_VIOL;
    endcase
    return v;
  endfunction

  // Write rules: input words guarded by DMA processing, mode by either phase
  function automatic verdict_t write_verdict(region_e r, logic proc, logic dma, logic key);
    verdict_t v;
    v = NO_VIOL;
    case (r)
      RG_DIN:
        if (proc && dma) v = '{hit: 1'b1, code: VC_DIN_DMA};
      RG_MODE: begin
        if (key)       v = '{hit: 1'b1, code: VC_MODE_KEY};
        else if (proc) v = '{hit: 1'b1, code: VC_MODE_PROC};
      end
      default: v = NO_VIOL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rag_decode.sv
module rag_decode
  import rag_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_WORDS = 4,
  parameter int DIN_BASE  = 8,
  parameter int DOUT_BASE = 16,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] DIN_LO  = ADDR_W'(DIN_BASE);
  localparam logic [ADDR_W-1:0] DOUT_LO = ADDR_W'(DOUT_BASE);
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_WORDS);

  logic [ADDR_W-1:0] din_off;
  logic [ADDR_W-1:0] dout_off;
  logic              in_din;
  logic              in_dout;

  assign din_off  = addr - DIN_LO;
  assign dout_off = addr - DOUT_LO;
  assign in_din   = (addr >= DIN_LO)  && (din_off  < SPAN);
  assign in_dout  = (addr >= DOUT_LO) && (dout_off < SPAN);

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (in_din) begin
      region = RG_DIN;
      idx    = din_off[IDX_W-1:0];
    end else if (in_dout) begin
      region = RG_DOUT;
      idx    = dout_off[IDX_W-1:0];
    end else begin
      case (addr)
        ADDR_W'(OFF_CTRL):   region = RG_CTRL;
        ADDR_W'(OFF_MODE):   region = RG_MODE;
        ADDR_W'(OFF_IEN):    region = RG_IEN;
        ADDR_W'(OFF_IDIS):   region = RG_IDIS;
        ADDR_W'(OFF_IMASK):  region = RG_IMASK;
        ADDR_W'(OFF_STATUS): region = RG_STATUS;
        default:             region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rag_rules.sv
module rag_rules
  import rag_pkg::*;
(
  input  logic    rd,
  input  logic    wr,
  input  region_e region,
  input  logic    proc,
  input  logic    dma,
  input  logic    key,
  output logic    rd_illegal,
  output logic    wr_illegal,
  output logic    viol_valid,
  output viol_e   viol_code
);

  verdict_t rv;
  verdict_t wv;

  always_comb begin
    rv = rd ? read_verdict(region, proc, key) : NO_VIOL;
    wv = wr ? write_verdict(region, proc, dma, key) : NO_VIOL;
  end

  assign rd_illegal = rv.hit;
  assign wr_illegal = wv.hit;
  assign viol_valid = rv.hit | wv.hit;
  // R12: a write violation's code takes precedence over a read violation's
  assign viol_code  = wv.hit ? wv.code : rv.code;

endmodule

// File: rtl/rag_store.sv
module rag_store
  import rag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swrst,
  input  logic                        wr,
  input  region_e                     region,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        wr_illegal,
  output logic [DATA_W-1:0]           mode_q,
  output logic [NUM_WORDS*DATA_W-1:0] din_q,
  output logic                        mask_q
);

  logic wr_ok;
  logic mode_blocked;

  assign wr_ok        = wr && !wr_illegal;
  assign mode_blocked = wr && wr_illegal && (region == RG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mode_q <= '0;
    else if (swrst)                          mode_q <= '0;
    else if (wr_ok && region == RG_MODE)     mode_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      mask_q <= 1'b0;
    else if (swrst)                                  mask_q <= 1'b0;
    else if (wr_ok && region == RG_IEN && wdata[0])  mask_q <= 1'b1;
    else if (wr_ok && region == RG_IDIS && wdata[0]) mask_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_din
    logic hit_g;
    assign hit_g = wr_ok && (region == RG_DIN) && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     din_q[g*DATA_W +: DATA_W] <= '0;
      else if (swrst) din_q[g*DATA_W +: DATA_W] <= '0;
      else if (hit_g) din_q[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  // R10: a blocked mode write leaves the register unchanged
  a_r10_mode_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_blocked && !swrst) |=> $stable(mode_q));

  // R11: the mask only rises through an enable write
  a_r11_mask_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q ##1 mask_q |-> $past(wr && region == RG_IEN));

endmodule

// File: rtl/rag_status.sv
module rag_status
  import rag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swrst,
  input  logic  viol_valid,
  input  viol_e viol_code,
  output logic  flag_q,
  output viol_e code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= VC_DIN_DMA;
    end else if (swrst) begin
      flag_q <= 1'b0;
      code_q <= VC_DIN_DMA;
    end else if (viol_valid) begin
      flag_q <= 1'b1;
      code_q <= viol_code;
    end
  end

  a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !swrst) |=> flag_q);

  a_r3_code_latest: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !swrst) |=> code_q == $past(viol_code));

  a_r4_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (!flag_q && code_q == VC_DIN_DMA));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !swrst) |=> flag_q);

  a_r4_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!swrst && !viol_valid) |=> $stable(code_q));

endmodule

// File: rtl/regaccess_guard.sv
module regaccess_guard
  import rag_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int DIN_BASE  = 8,
  parameter int DOUT_BASE = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        proc_busy,
  input  logic                        dma_mode,
  input  logic                        keygen_busy,
  input  logic [NUM_WORDS*DATA_W-1:0] dout_words,
  output logic [DATA_W-1:0]           mode_q,
  output logic [NUM_WORDS*DATA_W-1:0] din_words,
  output logic                        irq
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic              rd_illegal;
  logic              wr_illegal;
  logic              viol_valid;
  viol_e             viol_code;
  logic              swrst;
  logic              mask_q;
  logic              flag_q;
  viol_e             code_q;
  logic [DATA_W-1:0] rdata_raw;

  rag_decode #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
    .DIN_BASE(DIN_BASE), .DOUT_BASE(DOUT_BASE)
  ) u_decode (
    .addr(bus_addr), .region(region), .idx(idx)
  );

  rag_rules u_rules (
    .rd(bus_rd), .wr(bus_wr), .region(region),
    .proc(proc_busy), .dma(dma_mode), .key(keygen_busy),
    .rd_illegal(rd_illegal), .wr_illegal(wr_illegal),
    .viol_valid(viol_valid), .viol_code(viol_code)
  );

  assign swrst = bus_wr && (region == RG_CTRL) && bus_wdata[0];

  rag_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .swrst(swrst), .wr(bus_wr),
    .region(region), .idx(idx), .wdata(bus_wdata),
    .wr_illegal(wr_illegal), .mode_q(mode_q), .din_q(din_words),
    .mask_q(mask_q)
  );

  rag_status u_status (
    .clk(clk), .rst_n(rst_n), .swrst(swrst),
    .viol_valid(viol_valid), .viol_code(viol_code),
    .flag_q(flag_q), .code_q(code_q)
  );

  always_comb begin
    rdata_raw = '0;
    case (region)
      RG_MODE:   rdata_raw = mode_q;
      RG_IMASK:  rdata_raw[0] = mask_q;
      RG_STATUS: begin
        rdata_raw[0]    = flag_q;
        rdata_raw[10:8] = code_q;
      end
      RG_DOUT:   rdata_raw = dout_words[int'(idx)*DATA_W +: DATA_W];
      default:   rdata_raw = '0;
    endcase
  end

  assign bus_rdata = (bus_rd && !rd_illegal) ? rdata_raw : '0;
  assign irq       = flag_q & mask_q;

  // R9: a forbidden read never leaks data
  a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_illegal |-> (bus_rdata == '0));

  // R12: reset in the same cycle as a violation wins
  a_r12_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (swrst && viol_valid) |=> !irq);

endmodule

// File: tb/regaccess_guard_tb.sv
module regaccess_guard_tb;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic           proc_busy = 1'b0;
  logic           dma_mode = 1'b0;
  logic           keygen_busy = 1'b0;
  logic [NW*DW-1:0] dout_words;
  logic [DW-1:0]  mode_q;
  logic [NW*DW-1:0] din_words;
  logic           irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  for (genvar j = 0; j < NW; j++) begin : g_dout
    assign dout_words[j*DW +: DW] = 32'hD0D0_0000 + j;
  end

  regaccess_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .proc_busy(proc_busy), .dma_mode(dma_mode), .keygen_busy(keygen_busy),
    .dout_words(dout_words), .mode_q(mode_q), .din_words(din_words), .irq(irq)
  );

  localparam int K_WR_DIN = 0, K_RD_DOUT = 1, K_WR_MODE = 2, K_RD_MODE = 3,
                 K_RD_DIN = 4, K_RD_CTRL = 5, K_RD_IEN = 6, K_RD_IDIS = 7,
                 K_RD_STATUS = 8, K_RD_MASK = 9, K_WR_DOUT = 10,
                 K_WR_STATUS = 11, K_RD_UNMAP = 12, K_COUNT = 13;

  localparam logic [DW-1:0] PRESET = 32'h1234_5678;

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rv);
    @(negedge clk);
    bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1 rv = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] dummy;
    access(1'b0, 1'b1, a, d, dummy);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] v);
    access(1'b1, 1'b0, a, '0, v);
  endtask

  // status word model: flag in bit 0, code in bits 10:8
  function automatic logic [DW-1:0] st_word(input logic f, input int c);
    return (f ? 32'd1 : 32'd0) | (32'(c) << 8);
  endfunction

  // returns code, or -1 when the access is allowed
  function automatic int model(input int kind, input logic p, input logic d,
                               input logic ks);
    case (kind)
      K_WR_DIN:  return (p & d) ? 0 : -1;
      K_RD_DOUT: return ks ? 3 : (p ? 1 : -1);
      K_WR_MODE: return ks ? 4 : (p ? 2 : -1);
      K_RD_DIN, K_RD_CTRL, K_RD_IEN, K_RD_IDIS: return 5;
      default:   return -1;
    endcase
  endfunction

  function automatic string kreq(input int kind);
    case (kind)
      K_WR_DIN:  return "R5";
      K_RD_DOUT: return "R6";
      K_WR_MODE: return "R7";
      K_RD_DIN, K_RD_CTRL, K_RD_IEN, K_RD_IDIS: return "R8";
      K_WR_DOUT, K_WR_STATUS, K_RD_UNMAP: return "R13";
      default:   return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd_reg(6'd5, v);  check("R1", "reset status", v, 32'h0);
    check("R11", "reset irq", {31'b0, irq}, 32'h0);
    check("R4", "reset mode", mode_q, 32'h0);

    // sweep: phase x kind x word
    for (int ph = 0; ph < 8; ph++) begin
      for (int kind = 0; kind < K_COUNT; kind++) begin
        for (int k = 0; k < NW; k++) begin
          logic p, d, ks, en;
          int c;
          logic [AW-1:0] a;
          logic [DW-1:0] pat, exp_rd;
          logic is_rd;
          p = ph[0]; d = ph[1]; ks = ph[2]; en = (k % 2 == 0);
          pat = 32'hA500_0000 | (ph << 8) | (kind << 4) | k;
          proc_busy = 1'b0; dma_mode = 1'b0; keygen_busy = 1'b0;
          wr_reg(6'd0, 32'h1);
          wr_reg(6'd1, PRESET);
          if (en) wr_reg(6'd2, 32'h1);
          proc_busy = p; dma_mode = d; keygen_busy = ks;
          c = model(kind, p, d, ks);
          is_rd = 1'b1; exp_rd = '0;
          case (kind)
            K_WR_DIN:    begin a = 6'(8 + k);  is_rd = 1'b0; end
            K_RD_DOUT:   begin a = 6'(16 + k); exp_rd = 32'hD0D0_0000 + k; end
            K_WR_MODE:   begin a = 6'd1; is_rd = 1'b0; end
            K_RD_MODE:   begin a = 6'd1; exp_rd = PRESET; end
            K_RD_DIN:    a = 6'(8 + k);
            K_RD_CTRL:   a = 6'd0;
            K_RD_IEN:    a = 6'd2;
            K_RD_IDIS:   a = 6'd3;
            K_RD_STATUS: a = 6'd5;
            K_RD_MASK:   begin a = 6'd4; exp_rd = {31'b0, en}; end
            K_WR_DOUT:   begin a = 6'(16 + k); is_rd = 1'b0; end
            K_WR_STATUS: begin a = 6'd5; is_rd = 1'b0; end
            default:     a = 6'd6;
          endcase
          if (c >= 0) exp_rd = '0;
          access(is_rd, !is_rd, a, pat, v);
          if (is_rd) check(kreq(kind), "read data", v, exp_rd);
          rd_reg(6'd5, v);
          check(kreq(kind), "status", v, st_word(c >= 0, (c >= 0) ? c : 0));
          check("R11", "irq", {31'b0, irq}, {31'b0, (c >= 0) && en});
          check((kind == K_WR_MODE) ? "R10" : "R13", "mode",
                mode_q, (kind == K_WR_MODE && c < 0) ? pat : PRESET);
          check((kind == K_WR_DIN) ? "R10" : "R13", "din word",
                din_words[k*DW +: DW], (kind == K_WR_DIN && c < 0) ? pat : 32'h0);
        end
      end
    end

    // R3 overwrite, R4 clearing rules, R11 mask control
    proc_busy = 1'b0; dma_mode = 1'b0; keygen_busy = 1'b0;
    wr_reg(6'd0, 32'h1);
    proc_busy = 1'b1; dma_mode = 1'b1;
    wr_reg(6'd8, 32'hFFFF_FFFF);
    rd_reg(6'd5, v); check("R2", "code 0", v, st_word(1, 0));
    rd_reg(6'd0, v);
    rd_reg(6'd5, v); check("R3", "overwrite to 5", v, st_word(1, 5));
    wr_reg(6'd1, 32'h5);
    rd_reg(6'd5, v); check("R3", "overwrite to 2", v, st_word(1, 2));
    rd_reg(6'd5, v); check("R4", "status read keeps", v, st_word(1, 2));
    wr_reg(6'd5, 32'hFFFF_FFFF);
    rd_reg(6'd5, v); check("R4", "status write keeps", v, st_word(1, 2));
    wr_reg(6'd0, 32'h0000_0006);
    rd_reg(6'd5, v); check("R4", "ctrl bit0 clear keeps", v, st_word(1, 2));
    wr_reg(6'd2, 32'h1);
    check("R11", "irq on mask set", {31'b0, irq}, 32'h1);
    wr_reg(6'd3, 32'h1);
    check("R11", "irq off mask clear", {31'b0, irq}, 32'h0);
    rd_reg(6'd5, v); check("R4", "mask clear keeps flag", v, st_word(1, 2));
    wr_reg(6'd0, 32'h1);
    rd_reg(6'd5, v); check("R4", "swrst clears", v, 32'h0);

    // R12 both strobes
    proc_busy = 1'b1; dma_mode = 1'b1; keygen_busy = 1'b0;
    access(1'b1, 1'b1, 6'd9, 32'h77, v);
    check("R12", "read half zero", v, 32'h0);
    rd_reg(6'd5, v); check("R12", "write code wins", v, st_word(1, 0));
    check("R12", "din blocked", din_words[1*DW +: DW], 32'h0);
    access(1'b1, 1'b1, 6'd0, 32'h1, v);
    rd_reg(6'd5, v); check("R12", "reset wins", v, 32'h0);
    dma_mode = 1'b0;
    access(1'b1, 1'b1, 6'd17, 32'h99, v);
    check("R12", "dout read zero", v, 32'h0);
    rd_reg(6'd5, v); check("R12", "read code only", v, st_word(1, 1));
    keygen_busy = 1'b1;
    access(1'b1, 1'b1, 6'd1, 32'h42, v);
    rd_reg(6'd5, v); check("R12", "mode both strobes", v, st_word(1, 4));
    check("R10", "mode kept", mode_q, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule